// File: doc/BRIEF.md
# Power Supply Fault Supervisor

This block watches a multi-rail supply through digital comparator flags and decides when the supply is healthy and when it must be shut down. Each of five rails (3.3 V, 5 V, 12 V A, 12 V B, 12 V C) brings an over-voltage, an under-voltage and an over-current flag. A power-good input flag and an active-low, already debounced on-request input come in alongside them. Every flag passes through its own deglitch filter before the supervisor acts on it. Voltage flags and the power-good input use a short filter. Current flags use a much longer one.

Any qualified fault sets a fault latch. The latch drives the protection output high and pulls power-good low in the same cycle. Once the protection output has gone low, under-voltage and over-current faults are masked for a start-up window. That window is short while the filtered power-good input is high and long while it is low. Over-voltage is never masked. Power-good rises a fixed delay after the filtered power-good input becomes valid with the supply enabled. All timing is counted in ticks of an internal prescaler. The two outputs are logic levels; the pad wrapper turns them into pull-down enables.

Top module: `psu_fault_supervisor`

## Requirements
- R1: Each of the fifteen fault flags can set the fault latch on its own. Bit i of `ov_flag_i`, `uv_flag_i` and `oc_flag_i` belongs to rail i: 0 = 3.3 V, 1 = 5 V, 2 = 12 V A, 3 = 12 V B, 4 = 12 V C. A flag reads 1 when a fault is present.
- R2: A change on an over-voltage flag, an under-voltage flag or `pg_in_i` takes effect only after the new level has held for `DG_VOLT_TICKS` consecutive ticks. A shorter pulse has no effect.
- R3: An over-current flag counts only after it has held for `DG_CUR_TICKS` ticks. A pulse that is long enough to pass the voltage filter but shorter than this has no effect.
- R4: While the fault latch is set, `prot_o` is 1 and `pgood_o` is 0. Both take these values in the same cycle the latch sets.
- R5: Once set, the latch holds after the fault flags return to 0. It clears only on a clock edge where `on_req_n_i` is 1, and it stays clear while `on_req_n_i` stays 1.
- R6: `prot_o` equals the fault latch OR `on_req_n_i`. When there is no fault and `on_req_n_i` is driven to 0, `prot_o` goes low in the same cycle.
- R7: After `prot_o` falls, qualified under-voltage and over-current faults are ignored for `BLANK_PGOK_TICKS` ticks if the filtered power-good input is 1, or for `BLANK_PGLOW_TICKS` ticks if it is 0. The limit follows the current filtered level, so a rise of power-good can end a long window early.
- R8: A qualified over-voltage fault sets the latch even inside the start-up window.
- R9: `pgood_o` rises `PGOOD_TICKS` ticks after the filtered power-good input has been 1 with `prot_o` at 0. It falls as soon as the filtered input falls or `prot_o` rises.
- R10: A synchronous reset clears the latch, all filters and the power-good timer, so `pgood_o` is 0 and `prot_o` follows `on_req_n_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous power-on reset, active high |
| on_req_n_i | input | 1 | Debounced supply on-request, active low |
| pg_in_i | input | 1 | Power-good input comparator flag, 1 = above threshold |
| ov_flag_i | input | RAILS | Over-voltage flags, one per rail |
| uv_flag_i | input | RAILS | Under-voltage flags, one per rail |
| oc_flag_i | input | RAILS | Over-current flags, one per rail |
| prot_o | output | 1 | Protection output level, 1 = supply held off |
| pgood_o | output | 1 | Power-good output level, 1 = power good |

## Verification
The bench builds the block with a 4-cycle tick and uses small tick counts for every timer. The voltage filter takes 3 ticks, the current filter 10, the two blanking windows 30 and 90, and the power-good delay 25. With these values every window ends within a few hundred cycles. Glitches that pass the voltage filter but not the current filter, the switch from the long to the short blanking window when power-good rises, and a sweep of all fifteen fault flags therefore all fit in one short run. The spacing between the timers is still wide enough that each one can be sampled clearly before and after it expires.

// File: rtl/psu_sup_pkg.sv
package psu_sup_pkg;

  // counter width able to hold the value n
  function automatic int unsigned cw(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // length of the start-up mask, chosen by the filtered power-good level
  function automatic int unsigned window_ticks(input logic pg_ok,
                                               input int unsigned ok_t,
                                               input int unsigned low_t);
    return pg_ok ? ok_t : low_t;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psu_tick_gen.sv
module psu_tick_gen #(
  parameter int unsigned DIV = 100
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o
);
  import psu_sup_pkg::*;

  localparam int unsigned CW = cw(DIV);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |=> (DIV == 1) || !tick_o);  // R2
endmodule

// File: rtl/psu_deglitch.sv
module psu_deglitch #(
  parameter int unsigned TICKS = 73
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic raw_i,
  output logic filt_o
);
  import psu_sup_pkg::*;

  localparam int unsigned CW = cw(TICKS);

  logic [CW-1:0] cnt_q;
  logic          differs;
  logic          settle;

  assign differs = (raw_i != filt_o);
  assign settle  = differs && tick_i && (cnt_q == CW'(TICKS - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      filt_o <= 1'b0;
      cnt_q  <= '0;
    end else if (!differs) begin
      cnt_q  <= '0;
    end else if (settle) begin
      filt_o <= raw_i;
      cnt_q  <= '0;
    end else if (tick_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_DG_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i |=> $stable(filt_o));  // R2
  AST_DG_FOLLOWS_RAW: assert property (@(posedge clk_i) disable iff (rst_i)
    (raw_i == filt_o) |=> $stable(filt_o));  // R3
endmodule

// File: rtl/psu_blank_timer.sv
module psu_blank_timer #(
  parameter int unsigned OK_T  = 75000,
  parameter int unsigned LOW_T = 300000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic supply_off_i,
  input  logic pg_ok_i,
  output logic blank_o
);
  import psu_sup_pkg::*;

  localparam int unsigned MAXT = max_u(OK_T, LOW_T);
  localparam int unsigned EW   = cw(MAXT);

  logic [EW-1:0] elapsed_q;
  logic          saturated;

  assign saturated = (elapsed_q == EW'(MAXT));
  assign blank_o   = supply_off_i ||
                     (32'(elapsed_q) < window_ticks(pg_ok_i, OK_T, LOW_T));

  always_ff @(posedge clk_i) begin
    if (rst_i || supply_off_i)     elapsed_q <= '0;
    else if (tick_i && !saturated) elapsed_q <= elapsed_q + 1'b1;
  end

  AST_WINDOW_OPENS: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(supply_off_i) |-> blank_o);  // R7
endmodule

// File: rtl/psu_pgood_delay.sv
module psu_pgood_delay #(
  parameter int unsigned TICKS = 300000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic run_i,
  output logic done_o
);
  import psu_sup_pkg::*;

  localparam int unsigned CW = cw(TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (tick_i && !done_o) begin
      if (cnt_q == CW'(TICKS - 1)) done_o <= 1'b1;
      else                         cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_PG_DONE_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(done_o) |-> $past(run_i) && $past(tick_i));  // R9
endmodule

// File: rtl/psu_fault_supervisor.sv
module psu_fault_supervisor #(
  parameter int unsigned RAILS             = 5,
  parameter int unsigned TICK_DIV          = 100,
  parameter int unsigned DG_VOLT_TICKS     = 73,
  parameter int unsigned DG_CUR_TICKS      = 1200,
  parameter int unsigned BLANK_PGOK_TICKS  = 75000,
  parameter int unsigned BLANK_PGLOW_TICKS = 300000,
  parameter int unsigned PGOOD_TICKS       = 300000
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             on_req_n_i,
  input  logic             pg_in_i,
  input  logic [RAILS-1:0] ov_flag_i,
  input  logic [RAILS-1:0] uv_flag_i,
  input  logic [RAILS-1:0] oc_flag_i,
  output logic             prot_o,
  output logic             pgood_o
);

  logic             tick;
  logic [RAILS-1:0] ov_q, uv_q, oc_q;
  logic             pg_q;
  logic             blank;
  logic             ov_hit, masked_hit, fault_set;
  logic             latch_q;
  logic             pg_run, pg_done;

  psu_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_i(rst_i), .tick_o(tick)
  );

  genvar r;
  generate
    for (r = 0; r < RAILS; r++) begin : g_rail
      psu_deglitch #(.TICKS(DG_VOLT_TICKS)) u_ov (
        .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick),
        .raw_i(ov_flag_i[r]), .filt_o(ov_q[r])
      );
      psu_deglitch #(.TICKS(DG_VOLT_TICKS)) u_uv (
        .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick),
        .raw_i(uv_flag_i[r]), .filt_o(uv_q[r])
      );
      psu_deglitch #(.TICKS(DG_CUR_TICKS)) u_oc (
        .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick),
        .raw_i(oc_flag_i[r]), .filt_o(oc_q[r])
      );
    end
  endgenerate

  psu_deglitch #(.TICKS(DG_VOLT_TICKS)) u_pg (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick),
    .raw_i(pg_in_i), .filt_o(pg_q)
  );

  psu_blank_timer #(.OK_T(BLANK_PGOK_TICKS), .LOW_T(BLANK_PGLOW_TICKS)) u_blank (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick),
    .supply_off_i(prot_o), .pg_ok_i(pg_q), .blank_o(blank)
  );

  // fault qualification: over-voltage bypasses the start-up mask
  assign ov_hit     = |ov_q;
  assign masked_hit = !blank && ((|uv_q) || (|oc_q));
  assign fault_set  = !on_req_n_i && (ov_hit || masked_hit);

  always_ff @(posedge clk_i) begin
    if (rst_i || on_req_n_i) latch_q <= 1'b0;
    else if (fault_set)      latch_q <= 1'b1;
  end

  assign prot_o = latch_q || on_req_n_i;

  assign pg_run = pg_q && !prot_o;

  psu_pgood_delay #(.TICKS(PGOOD_TICKS)) u_pgd (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick),
    .run_i(pg_run), .done_o(pg_done)
  );

  assign pgood_o = pg_done && pg_run;

  AST_FAULT_KILLS_PG: assert property (@(posedge clk_i) disable iff (rst_i)
    latch_q |-> prot_o && !pgood_o);  // R4
  AST_CLEAR_ON_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
    on_req_n_i |=> !latch_q);  // R5
  AST_OV_UNMASKED: assert property (@(posedge clk_i) disable iff (rst_i)
    (!on_req_n_i && ov_hit) |=> prot_o);  // R8
  AST_MASK_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    (!latch_q && blank && !ov_hit) |=> !latch_q);  // R7
  AST_PG_NEEDS_INPUT: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(pgood_o) |-> pg_q);  // R9
endmodule

// File: tb/psu_fault_supervisor_tb.sv
module psu_fault_supervisor_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RAILS = 5;

  logic clk = 1'b0;
  logic rst;
  logic on_req_n;
  logic pg_in;
  logic [RAILS-1:0] ov, uv, oc;
  logic prot, pgood;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  psu_fault_supervisor #(
    .RAILS(RAILS), .TICK_DIV(4), .DG_VOLT_TICKS(3), .DG_CUR_TICKS(10),
    .BLANK_PGOK_TICKS(30), .BLANK_PGLOW_TICKS(90), .PGOOD_TICKS(25)
  ) dut_i (
    .clk_i(clk), .rst_i(rst), .on_req_n_i(on_req_n), .pg_in_i(pg_in),
    .ov_flag_i(ov), .uv_flag_i(uv), .oc_flag_i(oc),
    .prot_o(prot), .pgood_o(pgood)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic power_on(input logic pg);
    ov = '0; uv = '0; oc = '0;
    on_req_n = 1'b1;
    pg_in = pg;
    cyc(20);
    on_req_n = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; on_req_n = 1'b1; pg_in = 1'b0; ov = '0; uv = '0; oc = '0;
    cyc(4);
    rst = 1'b0;
    cyc(1);
    chk("R10", "prot after reset", prot, 1'b1);
    chk("R10", "pgood after reset", pgood, 1'b0);
  endtask

  task automatic t_pgood;
    power_on(1'b1);
    cyc(1);
    chk("R6", "prot low on request", prot, 1'b0);
    cyc(89);
    chk("R9", "pgood before delay", pgood, 1'b0);
    cyc(20);
    chk("R9", "pgood after delay", pgood, 1'b1);
    pg_in = 1'b0;
    cyc(5);
    chk("R2", "pgood during pg deglitch", pgood, 1'b1);
    cyc(10);
    chk("R9", "pgood drops with pg", pgood, 1'b0);
    pg_in = 1'b1;
    cyc(130);
    chk("R9", "pgood returns", pgood, 1'b1);
  endtask

  task automatic t_blank_short;
    power_on(1'b1);
    cyc(2);
    uv[2] = 1'b1;
    cyc(60);
    uv[2] = 1'b0;
    cyc(10);
    chk("R7", "uv masked in short window", prot, 1'b0);
    cyc(128);
    uv[2] = 1'b1;
    cyc(16);
    chk("R1", "uv latches after window", prot, 1'b1);
    chk("R4", "pgood low on fault", pgood, 1'b0);
    uv[2] = 1'b0;
    cyc(50);
    chk("R5", "latch holds after flag clears", prot, 1'b1);
    on_req_n = 1'b1;
    cyc(1);
    on_req_n = 1'b0;
    cyc(1);
    chk("R5", "latch cleared by off request", prot, 1'b0);
  endtask

  task automatic t_blank_long;
    power_on(1'b0);
    cyc(200);
    oc[4] = 1'b1;
    cyc(100);
    chk("R7", "oc masked in long window", prot, 1'b0);
    cyc(100);
    chk("R7", "oc latches after long window", prot, 1'b1);
    oc[4] = 1'b0;
    power_on(1'b0);
    cyc(140);
    oc[1] = 1'b1;
    cyc(60);
    chk("R7", "oc masked while pg low", prot, 1'b0);
    pg_in = 1'b1;
    cyc(30);
    chk("R7", "pg rise ends window early", prot, 1'b1);
    oc[1] = 1'b0;
  endtask

  task automatic t_ov_no_blank;
    power_on(1'b1);
    cyc(2);
    ov[0] = 1'b1;
    cyc(6);
    chk("R2", "ov not yet qualified", prot, 1'b0);
    cyc(12);
    chk("R8", "ov latches inside window", prot, 1'b1);
    ov[0] = 1'b0;
  endtask

  task automatic t_glitch;
    power_on(1'b1);
    cyc(200);
    ov[3] = 1'b1; cyc(5); ov[3] = 1'b0;
    cyc(20);
    chk("R2", "short ov pulse ignored", prot, 1'b0);
    uv[3] = 1'b1; cyc(6); uv[3] = 1'b0;
    cyc(20);
    chk("R2", "short uv pulse ignored", prot, 1'b0);
    oc[3] = 1'b1; cyc(25); oc[3] = 1'b0;
    cyc(50);
    chk("R3", "oc pulse under current filter ignored", prot, 1'b0);
    chk("R3", "pgood kept through glitches", pgood, 1'b1);
    oc[3] = 1'b1;
    cyc(30);
    chk("R3", "oc not yet qualified", prot, 1'b0);
    cyc(20);
    chk("R3", "held oc latches", prot, 1'b1);
    oc[3] = 1'b0;
  endtask

  task automatic t_all_flags;
    for (int cls = 0; cls < 3; cls++) begin
      for (int r = 0; r < RAILS; r++) begin
        power_on(1'b1);
        cyc(130);
        chk("R1", "quiet before flag", prot, 1'b0);
        case (cls)
          0: ov[r] = 1'b1;
          1: uv[r] = 1'b1;
          default: oc[r] = 1'b1;
        endcase
        cyc(cls == 2 ? 45 : 16);
        chk("R1", $sformatf("flag class %0d rail %0d", cls, r), prot, 1'b1);
        ov = '0; uv = '0; oc = '0;
      end
    end
  endtask

  task automatic t_reset_mid;
    power_on(1'b1);
    cyc(2);
    ov[1] = 1'b1;
    cyc(20);
    chk("R4", "fault before reset", prot, 1'b1);
    ov[1] = 1'b0;
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(1);
    chk("R10", "reset clears latch", prot, 1'b0);
    chk("R10", "reset clears pgood", pgood, 1'b0);
  endtask

  initial begin
    t_reset();
    t_pgood();
    t_blank_short();
    t_blank_long();
    t_ov_no_blank();
    t_glitch();
    t_all_flags();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule